// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable synchronous SRAM whose bus never needs an idle cycle when it changes between reads and writes. The address and the command are registered on a rising clock edge. The matching data phase then follows two enabled edges later, for a read and for a write alike. Read data are presented on the bus after that edge. Write data are taken from the bus at that edge. Because both kinds of access use the same two-stage offset, a controller can issue read, write, read, write in successive cycles and the bus stays busy on every cycle.

An active-low clock enable freezes the whole pipeline. A sleep input has the same freezing effect and keeps the array contents. Three chip enables qualify each new load. A load/advance strobe either loads a fresh address or steps a four-beat burst counter, in linear or interleaved order. The bus is split into separate input, output and output-enable ports, and an asynchronous output enable gates only the drive signal. The array holds 2^ADDR_W words, each made of NBYTE bytes of BYTE_W bits, and every byte has its own write enable.

Top module: `zbt_sram`

## Requirements
- R1: A read loaded at an enabled edge puts that word on dq_out, with dq_oe high, right after the second enabled edge that follows it. A write loaded at an enabled edge stores the dq_in value present at the second enabled edge that follows it.
- R2: When cen_n is high at an edge, all other synchronous inputs are ignored at that edge, including dq_in. No internal state changes at that edge, and dq_out and dq_oe keep their values.
- R3: A load (ld_n low) selects the device only when ce_a_n=0, ce_b_n=0 and ce_c=1. Any other combination starts a deselect cycle. A deselect cycle has no data phase, changes no array word, and ends any burst in progress.
- R4: Data phases already in the pipeline still complete after a deselect or a new write. dq_oe is low after the second enabled edge following the edge that sampled a deselect or a write.
- R5: bwe_n bit i (active low) enables the write of dq_in bits [BYTE_W*i+BYTE_W-1 : BYTE_W*i]. The enables are sampled with a write load and again on each advance beat of a write burst. The bytes they select are written when that beat reaches its data phase.
- R6: bwe_n has no effect on a read cycle.
- R7: dq_oe is low whenever oe_n is high. It follows oe_n without waiting for a clock edge.
- R8: While sleep is high, an edge acts exactly as if cen_n were high, and array contents are kept.
- R9: When ld_n is high and a burst is active, addr, wr_n and the chip enables are ignored. The next beat keeps the burst's direction and its upper address bits. The low two bits of beat k (k = 1, 2, 3, 0, ... counted modulo 4) are (base + k) mod 4 when burst_ilv=0 and base XOR k when burst_ilv=1. When ld_n is high and no burst is active, the cycle is idle.
- R10: Reads and writes can be issued on consecutive edges with no idle cycle between them. A read issued at any point after a write to the same address returns the new data.
- R11: After reset, dq_oe is low and no burst is active, so an advance is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset of pipeline and burst state |
| cen_n | input | 1 | Active-low clock enable; high freezes the block |
| sleep | input | 1 | High gates the internal clock and keeps contents |
| ce_a_n | input | 1 | Active-low chip enable A |
| ce_b_n | input | 1 | Active-low chip enable B |
| ce_c | input | 1 | Active-high chip enable C |
| ld_n | input | 1 | Low loads a new address, high advances the burst |
| wr_n | input | 1 | High read, low write, sampled on loads |
| burst_ilv | input | 1 | Static burst order: 0 linear, 1 interleaved |
| bwe_n | input | NBYTE | Active-low per-byte write enables |
| addr | input | ADDR_W | Word address |
| dq_in | input | NBYTE*BYTE_W | Write data from the bus |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_out | output | NBYTE*BYTE_W | Read data to the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The hardest case to reach from the ports is a data phase that must come out right while the pipeline is full and its flow keeps being broken: freeze or sleep cycles placed between a command and its data phase, with junk on dq_in and on the other inputs during the frozen edges. The bench reaches it through a scripted engine. The engine counts only enabled edges as slots, drives each write's data in the slot two after the write, and predicts every read from a program-order memory model. Each frozen edge sits between a command and its own data phase. The same engine also runs bursts in both orders from every start offset, deselect cycles that carry write attempts, and read/write interleaving on shared addresses.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    localparam int BEAT_W = 2;

    // Low address bits of a burst beat from the start offset and beat count.
    function automatic logic [BEAT_W-1:0] beat_offset(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input logic              interleave
    );
        return interleave ? (start ^ beat) : (start + beat);
    endfunction

endpackage

// File: rtl/zbt_issue.sv
module zbt_issue
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int NBYTE  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              load,
    input  logic              chip_sel,
    input  logic              read_req,
    input  logic              burst_ilv,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [NBYTE-1:0]  bwe_n_in,
    output op_e               cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [NBYTE-1:0]  cmd_bwe_n
);

    typedef struct packed {
        logic              active;
        logic              write;
        logic [ADDR_W-1:0] base;
        logic [BEAT_W-1:0] beat;
    } burst_t;

    burst_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        cmd_op    = OP_IDLE;
        cmd_addr  = st_q.base;
        cmd_bwe_n = '1;
        if (load) begin
            if (chip_sel) begin
                st_d.active = 1'b1;
                st_d.write  = !read_req;
                st_d.base   = addr_in;
                st_d.beat   = '0;
                cmd_op      = read_req ? OP_READ : OP_WRITE;
                cmd_addr    = addr_in;
            end else begin
                st_d.active = 1'b0;
            end
        end else if (st_q.active) begin
            st_d.beat = st_q.beat + 1'b1;
            cmd_op    = st_q.write ? OP_WRITE : OP_READ;
            cmd_addr  = {st_q.base[ADDR_W-1:BEAT_W],
                         beat_offset(st_q.base[BEAT_W-1:0], st_d.beat, burst_ilv)};
        end
        // Byte enables only travel with writes; reads carry none.
        if (cmd_op == OP_WRITE) begin
            cmd_bwe_n = bwe_n_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (step) begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
    parameter int ADDR_W = 10,
    parameter int NBYTE  = 4,
    parameter int BYTE_W = 9
) (
    input  logic                      clk,
    input  logic                      step,
    input  logic                      wr_en,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NBYTE-1:0]          bwe_n,
    input  logic [NBYTE*BYTE_W-1:0]   wdata,
    output logic [NBYTE*BYTE_W-1:0]   rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < NBYTE; g++) begin : g_lane
        logic [BYTE_W-1:0] mem_q [DEPTH];
        logic [BYTE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (step && wr_en && !bwe_n[g]) begin
                mem_q[addr] <= wdata[g*BYTE_W +: BYTE_W];
            end
            if (step && rd_en) begin
                rd_q <= mem_q[addr];
            end
        end

        assign rdata[g*BYTE_W +: BYTE_W] = rd_q;
    end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
    import zbt_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int NBYTE  = 4,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cen_n,
    input  logic                    sleep,
    input  logic                    ce_a_n,
    input  logic                    ce_b_n,
    input  logic                    ce_c,
    input  logic                    ld_n,
    input  logic                    wr_n,
    input  logic                    burst_ilv,
    input  logic [NBYTE-1:0]        bwe_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [NBYTE*BYTE_W-1:0] dq_in,
    input  logic                    oe_n,
    output logic [NBYTE*BYTE_W-1:0] dq_out,
    output logic                    dq_oe
);

    localparam int DATA_W = NBYTE * BYTE_W;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [NBYTE-1:0]  bwe_n;
    } stage_t;

    typedef struct packed {
        stage_t s1;
        stage_t s2;
        logic   drive;
    } pipe_t;

    pipe_t             pipe_d, pipe_q;
    logic              step;
    logic              chip_sel;
    op_e               cmd_op;
    logic [ADDR_W-1:0] cmd_addr;
    logic [NBYTE-1:0]  cmd_bwe_n;
    logic [DATA_W-1:0] rd_data;

    assign step     = !cen_n && !sleep;
    assign chip_sel = !ce_a_n && !ce_b_n && ce_c;

    zbt_issue #(
        .ADDR_W (ADDR_W),
        .NBYTE  (NBYTE)
    ) i_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (step),
        .load      (!ld_n),
        .chip_sel  (chip_sel),
        .read_req  (wr_n),
        .burst_ilv (burst_ilv),
        .addr_in   (addr),
        .bwe_n_in  (bwe_n),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_bwe_n (cmd_bwe_n)
    );

    always_comb begin
        pipe_d = pipe_q;
        if (step) begin
            pipe_d.s1.op    = cmd_op;
            pipe_d.s1.addr  = cmd_addr;
            pipe_d.s1.bwe_n = cmd_bwe_n;
            pipe_d.s2       = pipe_q.s1;
            pipe_d.drive    = (pipe_q.s2.op == OP_READ);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    zbt_array #(
        .ADDR_W (ADDR_W),
        .NBYTE  (NBYTE),
        .BYTE_W (BYTE_W)
    ) i_array (
        .clk   (clk),
        .step  (step),
        .wr_en (pipe_q.s2.op == OP_WRITE),
        .rd_en (pipe_q.s2.op == OP_READ),
        .addr  (pipe_q.s2.addr),
        .bwe_n (pipe_q.s2.bwe_n),
        .wdata (dq_in),
        .rdata (rd_data)
    );

    assign dq_out = rd_data;
    assign dq_oe  = pipe_q.drive && !oe_n;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cen_n,
    input logic              sleep,
    input logic              ce_a_n,
    input logic              ce_b_n,
    input logic              ce_c,
    input logic              ld_n,
    input logic              wr_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_oe
);

    logic go;
    logic sel;
    assign go  = !cen_n && !sleep;
    assign sel = !ce_a_n && !ce_b_n && ce_c;

    // R1: a selected read load drives the bus after two more enabled edges
    p_read_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !ld_n && sel && wr_n) ##1 go ##1 go |=> (oe_n || dq_oe));

    // R4: a write releases the bus at its data phase
    p_write_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !ld_n && sel && !wr_n) ##1 go ##1 go |=> !dq_oe);

    // R3: a deselect releases the bus at its data phase
    p_deselect_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !ld_n && !sel) ##1 go ##1 go |=> !dq_oe);

    // R2: a disabled edge leaves the outputs untouched
    p_freeze_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cen_n && !oe_n) |=> (oe_n || ($stable(dq_out) && $stable(dq_oe))));

    // R8: an edge during sleep leaves the outputs untouched
    p_sleep_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !oe_n) |=> (oe_n || ($stable(dq_out) && $stable(dq_oe))));

    // R7: output enable high blocks the drive
    p_oe_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

endmodule

bind zbt_sram zbt_sram_chk #(.DATA_W(DATA_W)) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cen_n  (cen_n),
    .sleep  (sleep),
    .ce_a_n (ce_a_n),
    .ce_b_n (ce_b_n),
    .ce_c   (ce_c),
    .ld_n   (ld_n),
    .wr_n   (wr_n),
    .oe_n   (oe_n),
    .dq_out (dq_out),
    .dq_oe  (dq_oe)
);

// File: tb/test_zbt_sram.sv
module test_zbt_sram;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 10;
    localparam int NBYTE  = 4;
    localparam int BYTE_W = 9;
    localparam int DATA_W = NBYTE * BYTE_W;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PMAX   = 1100;

    localparam int K_RD  = 0;
    localparam int K_WR  = 1;
    localparam int K_DES = 2;
    localparam int K_ADV = 3;
    localparam int K_FRZ = 4;
    localparam int K_SLP = 5;

    logic              clk = 1'b0;
    logic              rst_n, cen_n, sleep, ce_a_n, ce_b_n, ce_c;
    logic              ld_n, wr_n, burst_ilv, oe_n;
    logic [NBYTE-1:0]  bwe_n;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] dq_in;
    logic [DATA_W-1:0] dq_out;
    logic              dq_oe;

    zbt_sram #(.ADDR_W(ADDR_W), .NBYTE(NBYTE), .BYTE_W(BYTE_W)) i_zbt_sram (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .sleep(sleep),
        .ce_a_n(ce_a_n), .ce_b_n(ce_b_n), .ce_c(ce_c), .ld_n(ld_n),
        .wr_n(wr_n), .burst_ilv(burst_ilv), .bwe_n(bwe_n), .addr(addr),
        .dq_in(dq_in), .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    int salt    = 1;

    // Program storage
    int                op_kind [PMAX];
    logic [ADDR_W-1:0] op_addr [PMAX];
    logic [NBYTE-1:0]  op_bwe  [PMAX];
    logic [2:0]        op_ce   [PMAX];
    logic              op_oe   [PMAX];
    logic              op_wr   [PMAX];
    string             op_tag  [PMAX];
    int                n_ops = 0;

    // Per-slot history: 0 none, 1 read, 2 write
    int                h_kind [PMAX+8];
    logic [DATA_W-1:0] h_exp  [PMAX+8];
    logic [DATA_W-1:0] h_wd   [PMAX+8];
    string             h_tag  [PMAX+8];

    logic [DATA_W-1:0] model [DEPTH];
    bit                b_act = 0;
    bit                b_wr  = 0;
    logic [ADDR_W-1:0] b_base = '0;
    logic [1:0]        b_cnt  = '0;

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            summary();
            $finish;
        end
    end

    task automatic chk(bit ok, string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] pat(int s, int sl);
        logic [DATA_W-1:0] v;
        for (int b = 0; b < NBYTE; b++) begin
            v[b*BYTE_W +: BYTE_W] = BYTE_W'((s * 97 + b * 41 + sl * 13 + 5) % 512);
        end
        return v;
    endfunction

    task automatic add(int k, int a, logic [NBYTE-1:0] bw, string tag,
                       logic [2:0] ce = 3'b001, logic oe = 1'b0, logic w = 1'b0);
        op_kind[n_ops] = k;
        op_addr[n_ops] = ADDR_W'(a);
        op_bwe[n_ops]  = bw;
        op_ce[n_ops]   = ce;
        op_oe[n_ops]   = oe;
        op_wr[n_ops]   = w;
        op_tag[n_ops]  = tag;
        n_ops++;
    endtask

    // Record one enabled slot that carries an access, in program order.
    task automatic commit(int s, bit w, logic [ADDR_W-1:0] a, logic [NBYTE-1:0] bw, string tag);
        logic [DATA_W-1:0] d;
        h_tag[s] = tag;
        if (w) begin
            d = pat(s, salt);
            h_kind[s] = 2;
            h_wd[s]   = d;
            for (int b = 0; b < NBYTE; b++) begin
                if (!bw[b]) model[a][b*BYTE_W +: BYTE_W] = d[b*BYTE_W +: BYTE_W];
            end
        end else begin
            h_kind[s] = 1;
            h_exp[s]  = model[a];
        end
    endtask

    task automatic run_prog();
        int    nslot = 0;
        bit    frz_prev = 0;
        string frz_tag = "";
        for (int i = 0; i < n_ops + 3; i++) begin
            int                k;
            int                idx;
            string             tg;
            string             otag;
            logic [ADDR_W-1:0] a;
            logic [ADDR_W-1:0] ea;
            logic [NBYTE-1:0]  bw;
            @(negedge clk);
            // Outputs now reflect the slot three enabled edges back.
            idx = nslot - 3;
            tg  = frz_prev ? frz_tag : (idx >= 0 ? h_tag[idx] : "R11");
            if (idx >= 0 && h_kind[idx] == 1) begin
                chk(dq_oe === !oe_n, tg, DATA_W'(dq_oe), DATA_W'(!oe_n));
                if (!oe_n) chk(dq_out === h_exp[idx], tg, dq_out, h_exp[idx]);
            end else begin
                chk(dq_oe === 1'b0, tg, DATA_W'(dq_oe), '0);
            end
            if (i < n_ops) begin
                k = op_kind[i]; a = op_addr[i]; bw = op_bwe[i]; otag = op_tag[i];
            end else begin
                k = K_DES; a = '0; bw = '1; otag = "R3";
            end
            cen_n = 1'b0; sleep = 1'b0; ld_n = 1'b0; wr_n = 1'b1;
            {ce_a_n, ce_b_n, ce_c} = 3'b001;
            addr  = a;
            bwe_n = bw;
            oe_n  = (i < n_ops) ? op_oe[i] : 1'b0;
            dq_in = (nslot >= 2 && h_kind[nslot-2] == 2) ? h_wd[nslot-2] : pat(i + 7, 77);
            frz_prev = 0;
            case (k)
                K_RD, K_WR: begin
                    wr_n   = (k == K_RD);
                    b_act  = 1;
                    b_wr   = (k == K_WR);
                    b_base = a;
                    b_cnt  = '0;
                    commit(nslot, b_wr, a, bw, otag);
                    nslot++;
                end
                K_DES: begin
                    {ce_a_n, ce_b_n, ce_c} = (i < n_ops) ? op_ce[i] : 3'b000;
                    wr_n  = (i < n_ops) ? op_wr[i] : 1'b1;
                    b_act = 0;
                    h_kind[nslot] = 0;
                    h_tag[nslot]  = otag;
                    nslot++;
                end
                K_ADV: begin
                    ld_n = 1'b1;
                    addr = ~a;
                    wr_n = op_wr[i];
                    {ce_a_n, ce_b_n, ce_c} = op_ce[i];
                    if (b_act) begin
                        b_cnt = b_cnt + 2'd1;
                        ea = {b_base[ADDR_W-1:2],
                              burst_ilv ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt)};
                        commit(nslot, b_wr, ea, bw, otag);
                    end else begin
                        h_kind[nslot] = 0;
                        h_tag[nslot]  = otag;
                    end
                    nslot++;
                end
                default: begin
                    if (k == K_FRZ) cen_n = 1'b1;
                    else            sleep = 1'b1;
                    wr_n     = 1'b0;
                    addr     = ~a;
                    dq_in    = pat(i, 55);
                    frz_prev = 1;
                    frz_tag  = otag;
                end
            endcase
        end
        n_ops = 0;
        salt++;
    endtask

    initial begin
        logic [DATA_W-1:0] exp30;
        rst_n = 1'b0; cen_n = 1'b0; sleep = 1'b0; ce_a_n = 1'b0; ce_b_n = 1'b0; ce_c = 1'b0;
        ld_n = 1'b0; wr_n = 1'b1; burst_ilv = 1'b0; oe_n = 1'b0; bwe_n = '1; addr = '0; dq_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(dq_oe === 1'b0, "R11", DATA_W'(dq_oe), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dq_oe === 1'b0, "R11", DATA_W'(dq_oe), '0);

        // R11: advance straight after reset is idle; then R1 sweep of writes
        add(K_ADV, 5, 4'h0, "R11");
        for (int a = 0; a < DEPTH; a++) add(K_WR, a, 4'h0, "R1");
        run_prog();
        for (int a = 0; a < DEPTH; a++) add(K_RD, a, 4'h0, "R1");
        run_prog();

        // R10: back-to-back alternation on shared addresses
        for (int j = 0; j < 16; j++) begin
            int a = (j * 37) % DEPTH;
            add(K_WR, a, 4'h0, "R10");
            add(K_RD, a, 4'h0, "R10");
            add(K_RD, a ^ 1, 4'h0, "R10");
            add(K_WR, a ^ 1, 4'h0, "R10");
            add(K_RD, a ^ 1, 4'h0, "R10");
        end
        run_prog();

        // R5: every byte-enable pattern
        for (int m = 0; m < 16; m++) add(K_WR, 300 + m, 4'(m), "R5");
        for (int m = 0; m < 16; m++) add(K_RD, 300 + m, 4'h0, "R5");
        run_prog();

        // R6: byte enables on reads change nothing
        for (int m = 0; m < 4; m++) begin
            add(K_RD, 400 + m, 4'h0, "R6");
            add(K_RD, 400 + m, 4'(m * 5), "R6");
            add(K_RD, 400 + m, 4'h0, "R6");
        end
        run_prog();

        // R3: every non-selecting chip-enable combination with a write attempt
        add(K_RD, 500, 4'h0, "R3");
        add(K_ADV, 0, 4'h0, "R3");
        for (int c = 0; c < 8; c++) begin
            if (c != 1) begin
                add(K_DES, 500, 4'h0, "R3", 3'(c), 1'b0, 1'b0);
                add(K_ADV, 500, 4'h0, "R3");
                add(K_RD, 500, 4'h0, "R3");
            end
        end
        run_prog();

        // R4: pending phases survive deselects and new writes
        add(K_RD, 600, 4'h0, "R4");
        add(K_DES, 0, 4'h0, "R4", 3'b101);
        add(K_RD, 601, 4'h0, "R4");
        add(K_WR, 602, 4'h0, "R4");
        add(K_RD, 602, 4'h0, "R4");
        add(K_DES, 0, 4'h0, "R4", 3'b000);
        add(K_DES, 0, 4'h0, "R4", 3'b011);
        add(K_RD, 603, 4'h0, "R4");
        add(K_WR, 604, 4'h0, "R4");
        add(K_WR, 605, 4'h0, "R4");
        add(K_RD, 604, 4'h0, "R4");
        add(K_RD, 605, 4'h0, "R4");
        run_prog();

        // R9: bursts in both orders from every start offset, with wrap
        for (int ilv = 0; ilv < 2; ilv++) begin
            burst_ilv = 1'(ilv);
            for (int lo = 0; lo < 4; lo++) begin
                add(K_RD, 704 + lo, 4'h0, "R9");
                for (int b = 0; b < 5; b++) add(K_ADV, 704 + b, 4'h0, "R9", 3'(b), 1'b0, 1'(b));
                add(K_WR, 736 + 5 * lo, 4'h0, "R9");
                add(K_ADV, 0, 4'b0101, "R9", 3'b110, 1'b0, 1'b1);
                add(K_ADV, 0, 4'b1000, "R9");
                add(K_ADV, 0, 4'h0, "R9");
                for (int q = 0; q < 4; q++) add(K_RD, ((736 + 5 * lo) & ~3) + q, 4'h0, "R9");
            end
            run_prog();
        end
        burst_ilv = 1'b0;

        // R2: clock-enable freezes between commands and their data phases
        add(K_RD, 10, 4'h0, "R2");
        add(K_FRZ, 11, 4'h0, "R2");
        add(K_FRZ, 12, 4'h0, "R2");
        add(K_RD, 11, 4'h0, "R2");
        add(K_WR, 12, 4'h0, "R2");
        add(K_FRZ, 13, 4'h0, "R2");
        add(K_FRZ, 14, 4'h0, "R2");
        add(K_FRZ, 15, 4'h0, "R2");
        add(K_RD, 12, 4'h0, "R2");
        add(K_RD, 16, 4'h0, "R2");
        add(K_FRZ, 17, 4'h0, "R2");
        add(K_ADV, 0, 4'h0, "R2");
        add(K_FRZ, 18, 4'h0, "R2");
        add(K_ADV, 0, 4'h0, "R2");
        add(K_RD, 13, 4'h0, "R2");
        run_prog();

        // R8: sleep behaves as a freeze and keeps contents
        add(K_WR, 40, 4'h0, "R8");
        add(K_SLP, 41, 4'h0, "R8");
        add(K_RD, 40, 4'h0, "R8");
        add(K_SLP, 42, 4'h0, "R8");
        add(K_SLP, 43, 4'h0, "R8");
        add(K_RD, 41, 4'h0, "R8");
        add(K_SLP, 44, 4'h0, "R8");
        add(K_RD, 40, 4'h0, "R8");
        run_prog();

        // R7: output enable in the pipeline flow
        add(K_RD, 20, 4'h0, "R7", 3'b001, 1'b1);
        add(K_RD, 21, 4'h0, "R7", 3'b001, 1'b0);
        add(K_RD, 22, 4'h0, "R7", 3'b001, 1'b1);
        add(K_RD, 23, 4'h0, "R7", 3'b001, 1'b1);
        add(K_RD, 24, 4'h0, "R7", 3'b001, 1'b0);
        run_prog();

        // R7: output enable acts between clock edges
        @(negedge clk);
        exp30 = model[30];
        cen_n = 1'b0; sleep = 1'b0; ld_n = 1'b0; wr_n = 1'b1; oe_n = 1'b0;
        {ce_a_n, ce_b_n, ce_c} = 3'b001; addr = 10'd30;
        @(negedge clk);
        {ce_a_n, ce_b_n, ce_c} = 3'b000;
        b_act = 0;
        @(negedge clk);
        @(negedge clk);
        oe_n = 1'b1;
        #1;
        chk(dq_oe === 1'b0, "R7", DATA_W'(dq_oe), '0);
        oe_n = 1'b0;
        #1;
        chk(dq_oe === 1'b1, "R7", DATA_W'(dq_oe), DATA_W'(1));
        chk(dq_out === exp30, "R7", dq_out, exp30);
        repeat (3) @(negedge clk);

        done = 1;
        summary();
        $finish;
    end

endmodule